// File: doc/BRIEF.md
# Slot Identifier Map Engine

This block keeps a table with one 64-bit record identifier for each fixed-size storage slot, plus a count of the records currently held. A controller issues one command at a time: store an identifier, look one up for reading, erase one, or step an enumeration cursor through the stored records. For each command the engine returns a status code and the slot index to use. Payload movement between a staging buffer and the slots is left to the caller, which only needs the slot index that this block reports.

Two identifier values have fixed meanings. The all-zero value marks a free slot. The all-one value marks the end of an enumeration. Neither can be stored. Slots below the low bound of the command's index range are reserved and are never handed out, and index 0 is returned whenever no slot applies. The table sits in an internal array that is visited one entry per clock. A lookup stops as soon as it has passed as many occupied entries as the record count holds.

Top module: `slot_id_map`

## Requirements
- R1: A store (op 0) or erase (op 2) whose identifier is all zeros or all ones finishes with status 3, slot 0 and an unchanged record count.
- R2: A store (op 0) of an identifier that is not in the table writes it into the lowest free slot in [lo_idx, hi_idx), reports that slot with status 0 and raises the record count by one.
- R3: A store of an identifier already in the table reports the slot that holds it with status 0 and leaves the record count unchanged.
- R4: A store of a new identifier when no slot in the range is free finishes with status 1, slot 0 and an unchanged count.
- R5: An erase (op 2) of a stored identifier reports its slot with status 0, frees the slot so that a later store can reuse it, and lowers the count by one. An erase of an absent identifier gives status 5 and slot 0.
- R6: A read (op 1) while the record count is zero finishes with status 4.
- R7: A read of a stored identifier returns status 0, its slot and the identifier on id_out. A read of identifier 0 acts on the lowest-slot stored record. A read of all ones gives status 3. A read of an absent identifier gives status 5, slot 0, and the lowest-slot stored identifier on id_out.
- R8: Get-next (op 3) returns status 0 with the identifier and slot of the next occupied slot at or after the cursor, in ascending slot order, and moves the cursor past it. When no slot is left, it returns all ones with slot 0 and sends the cursor back to lo_idx, so the following get-next starts over.
- R9: A lookup stops once it has passed as many occupied slots as the record count holds. With a single record in slot lo_idx, an erase of an absent identifier raises done on the third clock after the start cycle.
- R10: busy is high from the clock after start or init up to and including the single-cycle done pulse. status, slot and id_out hold their values after done until the next command.
- R11: Reset clears busy and done and returns the cursor to lo_idx. It leaves the table and the record count unchanged.
- R12: init frees every table entry and zeroes the record count, with busy held high until done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Start a sweep that frees every entry (taken when idle) |
| start | input | 1 | Start the command on op (taken when idle) |
| op | input | 2 | 0 store, 1 read, 2 erase, 3 get-next |
| lo_idx | input | IW | First allocatable slot |
| hi_idx | input | IW | One past the last allocatable slot |
| id_in | input | ID_W | Identifier operand |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | 0 ok, 1 no space, 3 failed, 4 empty, 5 not found |
| slot | output | IW | Selected slot, 0 when none applies |
| id_out | output | ID_W | Identifier result of a read or get-next |
| rec_count | output | CW | Number of stored records |

## Verification
The stimulus mixes stores of fresh identifiers, repeat stores, reserved values and stores into a full range. This separates allocation of the lowest free slot from in-place overwrite and from the no-space outcome. Erases of present and absent identifiers, followed by a store, show that a freed slot is reused. A get-next sequence that runs past the last record checks the ascending order, the end marker and the wrap to the start. Reads of present, zero, absent and all-one identifiers tell the substitution paths apart. Completion latency is measured with a single record present, which shows whether the lookup stops early. A reset between get-next commands shows whether the cursor returns to the start while the stored records are kept.

// File: rtl/slot_id_map.sv
module slot_id_map #(
  parameter int ID_W  = 64,
  parameter int SLOTS = 16,
  localparam int AW = $clog2(SLOTS),
  localparam int IW = AW + 1,
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init,
  input  logic            start,
  input  logic [1:0]      op,
  input  logic [IW-1:0]   lo_idx,
  input  logic [IW-1:0]   hi_idx,
  input  logic [ID_W-1:0] id_in,
  output logic            busy,
  output logic            done,
  output logic [2:0]      status,
  output logic [IW-1:0]   slot,
  output logic [ID_W-1:0] id_out,
  output logic [CW-1:0]   rec_count
);
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_CLR = 2'd2, OP_NX = 2'd3;
  localparam logic [2:0] ST_OK = 3'd0, ST_NOSPC = 3'd1, ST_FAIL = 3'd3,
                         ST_EMPTY = 3'd4, ST_MISS = 3'd5;
  localparam logic [ID_W-1:0] ONES = '1;

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_FREE, S_NEXT, S_INIT, S_FIN} st_t;

  logic [ID_W-1:0] mem [SLOTS];
  st_t             st;
  logic [1:0]      op_q;
  logic [ID_W-1:0] key, idq;
  logic [IW-1:0]   ptr, lo_q, hi_q, cur, slot_q;
  logic [CW-1:0]   seen, cnt;
  logic [2:0]      stat;
  logic            miss;
  logic            mem_we, cnt_inc, cnt_dec, cnt_clr;
  logic [ID_W-1:0] mem_wd;

  function automatic logic valid_id(input logic [ID_W-1:0] v);
    return (v != '0) && (v != ONES);
  endfunction

  wire [ID_W-1:0] ent    = mem[ptr[AW-1:0]];
  wire            occ    = ent != '0;
  wire            at_end = (ptr >= hi_q) || (ptr >= IW'(SLOTS));
  wire            l_stop = at_end || (seen >= cnt);

  assign busy      = st != S_IDLE;
  assign done      = st == S_FIN;
  assign status    = stat;
  assign slot      = slot_q;
  assign id_out    = idq;
  assign rec_count = cnt;

  always_comb begin
    mem_we = 1'b0; mem_wd = '0;
    cnt_inc = 1'b0; cnt_dec = 1'b0; cnt_clr = 1'b0;
    case (st)
      S_LOOK: if (!l_stop && ent == key) begin
        if (op_q == OP_WR) begin mem_we = 1'b1; mem_wd = key; end
        if (op_q == OP_CLR) begin mem_we = 1'b1; cnt_dec = 1'b1; end
      end
      S_FREE: if (!at_end && !occ) begin
        mem_we = 1'b1; mem_wd = key; cnt_inc = 1'b1;
      end
      S_INIT: begin mem_we = 1'b1; cnt_clr = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[ptr[AW-1:0]] <= mem_wd;
    if (cnt_clr)      cnt <= '0;
    else if (cnt_inc) cnt <= cnt + 1'b1;
    else if (cnt_dec) cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cur <= lo_idx; stat <= ST_OK; slot_q <= '0; idq <= '0;
      ptr <= '0; lo_q <= '0; hi_q <= '0; seen <= '0; key <= '0;
      op_q <= OP_WR; miss <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (init) begin
          st <= S_INIT; ptr <= '0; lo_q <= lo_idx; slot_q <= '0;
        end else if (start) begin
          op_q <= op; key <= id_in; idq <= id_in; lo_q <= lo_idx; hi_q <= hi_idx;
          ptr <= lo_idx; seen <= '0; miss <= 1'b0; slot_q <= '0; stat <= ST_OK;
          case (op)
            OP_WR, OP_CLR:
              if (!valid_id(id_in)) begin stat <= ST_FAIL; st <= S_FIN; end
              else st <= S_LOOK;
            OP_RD:
              if (cnt == '0)          begin stat <= ST_EMPTY; st <= S_FIN; end
              else if (id_in == ONES) begin stat <= ST_FAIL;  st <= S_FIN; end
              else if (id_in == '0)   st <= S_NEXT;
              else                    st <= S_LOOK;
            default: begin
              ptr <= cur;
              if (cnt == '0) begin idq <= ONES; cur <= lo_idx; st <= S_FIN; end
              else st <= S_NEXT;
            end
          endcase
        end
        S_LOOK: if (l_stop) begin
          case (op_q)
            OP_WR:   begin st <= S_FREE; ptr <= lo_q; end
            OP_RD:   begin miss <= 1'b1; ptr <= lo_q; st <= S_NEXT; end
            default: begin stat <= ST_MISS; st <= S_FIN; end
          endcase
        end else if (ent == key) begin
          slot_q <= ptr; idq <= key; stat <= ST_OK; st <= S_FIN;
        end else begin
          if (occ) seen <= seen + 1'b1;
          ptr <= ptr + 1'b1;
        end
        S_FREE: if (at_end) begin
          stat <= ST_NOSPC; st <= S_FIN;
        end else if (!occ) begin
          slot_q <= ptr; stat <= ST_OK; st <= S_FIN;
        end else ptr <= ptr + 1'b1;
        S_NEXT: if (at_end) begin
          cur <= lo_q; idq <= ONES; st <= S_FIN;
          if (op_q == OP_NX) stat <= ST_OK;
          else stat <= miss ? ST_MISS : ST_FAIL;
        end else if (occ) begin
          cur <= ptr + 1'b1; idq <= ent;
          if (op_q == OP_NX) begin
            stat <= ST_OK; slot_q <= ptr; st <= S_FIN;
          end else if (miss) begin
            stat <= ST_MISS; st <= S_FIN;
          end else begin
            key <= ent; ptr <= lo_q; seen <= '0; st <= S_LOOK;
          end
        end else ptr <= ptr + 1'b1;
        S_INIT: if (ptr == IW'(SLOTS - 1)) begin
          cur <= lo_q; stat <= ST_OK; st <= S_FIN;
        end else ptr <= ptr + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module slot_id_map_chk #(
  parameter int SLOTS = 16,
  localparam int IW = $clog2(SLOTS) + 1,
  localparam int CW = $clog2(SLOTS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          init,
  input logic          start,
  input logic [IW-1:0] lo_idx,
  input logic          busy,
  input logic          done,
  input logic [2:0]    status,
  input logic [IW-1:0] slot,
  input logic [CW-1:0] rec_count
);
  a_r10_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start || init));
  a_r5_bad_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status != 3'd0) |-> slot == '0);
  a_r2_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (done && slot != '0) |-> slot >= lo_idx);
  a_r11_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && !init) |=> $stable(rec_count));
  a_r6_status_code: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status == 3'd0 || status == 3'd1 || status == 3'd3 ||
              status == 3'd4 || status == 3'd5));
endmodule

bind slot_id_map slot_id_map_chk #(.SLOTS(SLOTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .init(init), .start(start), .lo_idx(lo_idx),
  .busy(busy), .done(done), .status(status), .slot(slot), .rec_count(rec_count)
);

// File: tb/slot_id_map_tb_top.sv
module slot_id_map_tb_top;
  localparam int ID_W = 64, SLOTS = 16, IW = 5, CW = 5;
  localparam logic [ID_W-1:0] ONES = '1;
  localparam logic [1:0] WR = 0, RD = 1, CLR = 2, NX = 3;

  logic clk = 0, rst_n = 0, init = 0, start = 0;
  logic [1:0] op = 0;
  logic [IW-1:0] lo_idx = 5'd2, hi_idx = 5'd8;
  logic [ID_W-1:0] id_in = '0;
  logic busy, done;
  logic [2:0] status;
  logic [IW-1:0] slot;
  logic [ID_W-1:0] id_out;
  logic [CW-1:0] rec_count;
  int vectors = 0, miscompares = 0, lat = 0;

  always #5 clk = ~clk;

  slot_id_map #(.ID_W(ID_W), .SLOTS(SLOTS)) dut_i (
    .clk(clk), .rst_n(rst_n), .init(init), .start(start), .op(op),
    .lo_idx(lo_idx), .hi_idx(hi_idx), .id_in(id_in), .busy(busy), .done(done),
    .status(status), .slot(slot), .id_out(id_out), .rec_count(rec_count));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_done(string tag);
    lat = 1;
    while (!done && lat < 100) begin
      if (!busy) check({tag, " R10 busy"}, 0, 1);
      @(negedge clk); lat++;
    end
    if (!done) check({tag, " watchdog"}, 0, 1);
  endtask

  task automatic cmd(string tag, logic [1:0] o, logic [ID_W-1:0] id,
                     logic [2:0] es, logic [IW-1:0] esl, logic chk_id,
                     logic [ID_W-1:0] eid, logic [CW-1:0] ec);
    @(negedge clk); start = 1; op = o; id_in = id;
    @(negedge clk); start = 0;
    wait_done(tag);
    check({tag, " status"}, 64'(status), 64'(es));
    check({tag, " slot"}, 64'(slot), 64'(esl));
    if (chk_id) check({tag, " id"}, id_out, eid);
    check({tag, " count"}, 64'(rec_count), 64'(ec));
    @(negedge clk);
    check({tag, " R10 idle after done"}, {62'd0, busy, done}, 0);
    check({tag, " R10 status held"}, 64'(status), 64'(es));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    check("R11 busy/done in reset", {62'd0, busy, done}, 0);
    rst_n = 1;
  endtask

  task automatic t_init();
    @(negedge clk); init = 1;
    @(negedge clk); init = 0;
    wait_done("R12 init");
    check("R12 count zero", 64'(rec_count), 0);
  endtask

  task automatic t_empty();
    cmd("R8 next on empty", NX, 0, 0, 0, 1, ONES, 0);
    cmd("R6 read empty", RD, 64'h11, 4, 0, 0, 0, 0);
  endtask

  task automatic t_write();
    cmd("R2 store A", WR, 64'h11, 0, 2, 0, 0, 1);
    cmd("R2 store B", WR, 64'h22, 0, 3, 0, 0, 2);
    cmd("R2 store C", WR, 64'h33, 0, 4, 0, 0, 3);
    cmd("R3 overwrite B", WR, 64'h22, 0, 3, 0, 0, 3);
  endtask

  task automatic t_reserved();
    cmd("R1 store zero", WR, 0, 3, 0, 0, 0, 3);
    cmd("R1 store ones", WR, ONES, 3, 0, 0, 0, 3);
    cmd("R1 erase zero", CLR, 0, 3, 0, 0, 0, 3);
  endtask

  task automatic t_clear();
    cmd("R5 erase B", CLR, 64'h22, 0, 3, 0, 0, 2);
    cmd("R5 erase absent", CLR, 64'h22, 5, 0, 0, 0, 2);
    cmd("R5 reuse freed slot", WR, 64'h44, 0, 3, 0, 0, 3);
  endtask

  task automatic t_enum();
    cmd("R8 next 1", NX, 0, 0, 2, 1, 64'h11, 3);
    cmd("R8 next 2", NX, 0, 0, 3, 1, 64'h44, 3);
    cmd("R8 next 3", NX, 0, 0, 4, 1, 64'h33, 3);
    cmd("R8 next end", NX, 0, 0, 0, 1, ONES, 3);
    cmd("R8 next wrap", NX, 0, 0, 2, 1, 64'h11, 3);
  endtask

  task automatic t_read();
    cmd("R7 read C", RD, 64'h33, 0, 4, 1, 64'h33, 3);
    cmd("R7 read zero", RD, 0, 0, 2, 1, 64'h11, 3);
    cmd("R7 read absent", RD, 64'h99, 5, 0, 1, 64'h11, 3);
    cmd("R7 read ones", RD, ONES, 3, 0, 0, 0, 3);
  endtask

  task automatic t_full();
    cmd("R2 store 5", WR, 64'h55, 0, 5, 0, 0, 4);
    cmd("R2 store 6", WR, 64'h66, 0, 6, 0, 0, 5);
    cmd("R2 store 7", WR, 64'h77, 0, 7, 0, 0, 6);
    cmd("R4 store full", WR, 64'h88, 1, 0, 0, 0, 6);
  endtask

  task automatic t_retain();
    do_reset();
    @(negedge clk);
    check("R11 count kept", 64'(rec_count), 6);
    cmd("R11 cursor reset", NX, 0, 0, 2, 1, 64'h11, 6);
  endtask

  task automatic t_early();
    t_init();
    cmd("R9 store single", WR, 64'h11, 0, 2, 0, 0, 1);
    cmd("R9 erase absent", CLR, 64'h99, 5, 0, 0, 0, 1);
    check("R9 early stop latency", 64'(lat), 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset busy/done", {62'd0, busy, done}, 0);
    rst_n = 1;
    t_init();
    t_empty();
    t_write();
    t_reserved();
    t_clear();
    t_enum();
    t_read();
    t_full();
    t_retain();
    t_early();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1000000;
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule